// File: doc/BRIEF.md
# SD/MMC Host Control Register Block

This block is the register-mapped control plane of an SD/MMC host controller. Software reaches it over a simple register bus with zero wait states. Through it, software starts and stops the card clock, sets the card clock divider, fills in the command setup word, and programs the response and read timeout limits. It can also launch a command operation or reset the controller. The serial engines for the command and data lines and the FIFOs sit outside the block. They receive the command setup, the timeout limits, a one-cycle start pulse and four auxiliary strobes from it.

The engines report events on single-bit inputs. Each event sets its own bit in a write-one-to-clear interrupt status register. A mask register with the same layout blocks a source when its bit is 1. The registered interrupt output is high when any status bit is set and not masked.

A reset strobe starts a fixed countdown. During the countdown a busy flag is visible in the status register and bus writes are ignored. At the end of the countdown every register returns to its default value.

Top module: `sdhost_ctrl_regs`

Register words are selected by byte address bits 4:2:

| Offset | Register |
|---|---|
| 0x00 | control strobes (write only, reads 0) |
| 0x04 | status (read only) |
| 0x08 | clock rate |
| 0x0C | command setup |
| 0x10 | response timeout |
| 0x14 | read timeout |
| 0x18 | interrupt mask |
| 0x1C | interrupt status |

## Requirements
- R1: After rst_n is released, the registers read as follows: status 0, clock rate 0, command setup 0, interrupt status 0, interrupt mask 0x3FF, response timeout 0xFFFF and read timeout 0xFFFFFFFF. The outputs irq, card_clk and op_start are 0.
- R2: A control write with bit 1 set enables the card clock, and status bit 8 reads 1 from the next cycle. A control write with bit 0 set disables the clock, and status bit 8 reads 0 from the next cycle. If both bits are set, stop wins. While the clock is disabled, card_clk is low from the cycle after status bit 8 falls.
- R3: The clock rate register holds a 3-bit field n in bits 2:0. Each high phase and each low phase of card_clk lasts 2^n clk cycles. Higher bits are dropped on write and read as 0.
- R4: A control write with bit 2 set gives a single-cycle op_start pulse in the cycle after the write. Control bits 7:4 (read-wait stop, read-wait start, exit transfer, exit multi-block) appear on aux_strobe[3:0] in the same way. The control register reads 0.
- R5: A control write with bit 3 set holds status bit 15 at 1 for exactly 8 cycles. No strobe or register write takes effect during those cycles, and no op_start pulse is produced. At the end of the countdown all registers hold the R1 default values.
- R6: The event inputs set interrupt status bits as follows: bit 0 transfer done, bit 1 program done, bit 2 command response done, bit 5 RX request, bit 6 TX request, bit 7 SDIO, bit 8 read timeout, bit 9 response timeout. Bits 3 and 4 always read 0.
- R7: Writing 1 to an interrupt status bit clears it. Writing 0 leaves the bit unchanged.
- R8: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R9: irq is the OR of the interrupt status bits whose mask bit is 0. It is registered, so it follows a change in status or mask by one cycle. A mask bit of 1 blocks its source.
- R10: The command setup register keeps bits 11:0 and drives cmd_cfg. Bits 2:0 are the response format, bit 3 data enable, bit 4 write, bit 5 stream, bit 6 busy, bit 7 init, bit 8 DMA, bits 10:9 bus width and bit 11 IO abort. The response timeout register keeps 16 bits and drives resp_limit. The read timeout register keeps 32 bits and drives read_limit.
- R11: bus_ready equals bus_en. Read data is valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_en | input | 1 | bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | byte address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data |
| bus_ready | output | 1 | access accepted |
| ev_xfer_done | input | 1 | data transfer done event |
| ev_prog_done | input | 1 | programming done event |
| ev_cmd_done | input | 1 | command response done event |
| ev_rx_req | input | 1 | RX FIFO read request event |
| ev_tx_req | input | 1 | TX FIFO write request event |
| ev_sdio | input | 1 | SDIO card interrupt event |
| ev_rd_tmo | input | 1 | read timeout event |
| ev_resp_tmo | input | 1 | response timeout event |
| card_clk | output | 1 | gated, divided card clock |
| op_start | output | 1 | start pulse to the command engine |
| aux_strobe | output | 4 | read-wait stop/start, exit transfer, exit multi-block pulses |
| cmd_cfg | output | CMD_W | command setup word |
| resp_limit | output | RTO_W | response timeout limit |
| read_limit | output | DTO_W | read timeout limit |
| irq | output | 1 | level interrupt |

## Verification
A hardware event and a software write-one-to-clear of the same interrupt status bit can fall in the same clock cycle. The bench provokes this by raising the SDIO event during the same cycle as a bus write that clears every implemented status bit. The result is judged by reading back the interrupt status: the SDIO bit must still be set and every other bit must be cleared. A second collision checked is a start strobe written while the reset countdown is running, which must produce no op_start pulse.

// File: rtl/sdhost_ctrl_regs.sv
module sdhost_ctrl_regs #(
  parameter int ADDR_W     = 5,
  parameter int DIV_BITS   = 3,
  parameter int RST_CYCLES = 8,
  parameter int CMD_W      = 12,
  parameter int RTO_W      = 16,
  parameter int DTO_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  input  logic              ev_xfer_done,
  input  logic              ev_prog_done,
  input  logic              ev_cmd_done,
  input  logic              ev_rx_req,
  input  logic              ev_tx_req,
  input  logic              ev_sdio,
  input  logic              ev_rd_tmo,
  input  logic              ev_resp_tmo,
  output logic              card_clk,
  output logic              op_start,
  output logic [3:0]        aux_strobe,
  output logic [CMD_W-1:0]  cmd_cfg,
  output logic [RTO_W-1:0]  resp_limit,
  output logic [DTO_W-1:0]  read_limit,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int CNT_W = (1 << DIV_BITS) - 1;
  localparam int RC_W  = $clog2(RST_CYCLES + 1);
  localparam logic [9:0] IRQ_IMPL = 10'b11_1110_0111;

  logic [IDX_W-1:0]    idx;
  logic [RC_W-1:0]     rst_cnt;
  logic                busy, soft_done, wr;
  logic                wr_ctl, wr_rate, wr_cmd, wr_rto, wr_dto, wr_mask, wr_ist;
  logic                clk_on;
  logic [DIV_BITS-1:0] rate;
  logic [CNT_W-1:0]    div_cnt, div_lim;
  logic [9:0]          mask, ist, ev_vec, clr_vec;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign busy      = (rst_cnt != '0);
  assign soft_done = (rst_cnt == RC_W'(1));
  assign wr        = bus_en & bus_we & ~busy;
  assign wr_ctl    = wr && idx == IDX_W'(0);
  assign wr_rate   = wr && idx == IDX_W'(2);
  assign wr_cmd    = wr && idx == IDX_W'(3);
  assign wr_rto    = wr && idx == IDX_W'(4);
  assign wr_dto    = wr && idx == IDX_W'(5);
  assign wr_mask   = wr && idx == IDX_W'(6);
  assign wr_ist    = wr && idx == IDX_W'(7);
  assign bus_ready = bus_en;

  assign ev_vec  = {ev_resp_tmo, ev_rd_tmo, ev_sdio, ev_tx_req, ev_rx_req,
                    2'b00, ev_cmd_done, ev_prog_done, ev_xfer_done} & IRQ_IMPL;
  assign clr_vec = wr_ist ? bus_wdata[9:0] : 10'd0;
  assign div_lim = CNT_W'((1 << rate) - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          rst_cnt <= '0;
    else if (wr_ctl && bus_wdata[3])     rst_cnt <= RC_W'(RST_CYCLES);
    else if (busy)                       rst_cnt <= rst_cnt - RC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_on <= 1'b0; rate <= '0; cmd_cfg <= '0; mask <= '1; ist <= '0;
      resp_limit <= '1; read_limit <= '1; irq <= 1'b0;
      op_start <= 1'b0; aux_strobe <= '0;
    end else if (soft_done) begin
      clk_on <= 1'b0; rate <= '0; cmd_cfg <= '0; mask <= '1; ist <= '0;
      resp_limit <= '1; read_limit <= '1; irq <= 1'b0;
      op_start <= 1'b0; aux_strobe <= '0;
    end else begin
      op_start   <= wr_ctl & bus_wdata[2] & ~bus_wdata[3];
      aux_strobe <= (wr_ctl & ~bus_wdata[3]) ? bus_wdata[7:4] : 4'd0;
      if (wr_ctl && bus_wdata[0])      clk_on <= 1'b0;
      else if (wr_ctl && bus_wdata[1]) clk_on <= 1'b1;
      if (wr_rate) rate       <= bus_wdata[DIV_BITS-1:0];
      if (wr_cmd)  cmd_cfg    <= bus_wdata[CMD_W-1:0];
      if (wr_rto)  resp_limit <= bus_wdata[RTO_W-1:0];
      if (wr_dto)  read_limit <= bus_wdata[DTO_W-1:0];
      if (wr_mask) mask       <= bus_wdata[9:0];
      if (!busy)   ist        <= (ist & ~clr_vec) | ev_vec;
      irq <= |(ist & ~mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0; card_clk <= 1'b0;
    end else if (!clk_on) begin
      div_cnt <= '0; card_clk <= 1'b0;
    end else if (div_cnt >= div_lim) begin
      div_cnt <= '0; card_clk <= ~card_clk;
    end else begin
      div_cnt <= div_cnt + CNT_W'(1);
    end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IDX_W'(1): begin bus_rdata[15] = busy; bus_rdata[8] = clk_on; end
      IDX_W'(2): bus_rdata[DIV_BITS-1:0] = rate;
      IDX_W'(3): bus_rdata[CMD_W-1:0]    = cmd_cfg;
      IDX_W'(4): bus_rdata[RTO_W-1:0]    = resp_limit;
      IDX_W'(5): bus_rdata[DTO_W-1:0]    = read_limit;
      IDX_W'(6): bus_rdata[9:0]          = mask;
      IDX_W'(7): bus_rdata[9:0]          = ist;
      default:   bus_rdata = '0;
    endcase
  end

  a_r2_stopped_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on |=> !card_clk);
  a_r5_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_start);
  a_r5_defaults_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ist == '0 && mask == '1 && !clk_on && resp_limit == '1 && read_limit == '1));
  a_r6_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ist[4:3] == 2'b00);
  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ist |=> (ist & $past(bus_wdata[9:0] & ~ev_vec)) == '0);
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ev_vec != '0) |=> (ist & $past(ev_vec)) == $past(ev_vec));
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1 && $past(mask) == '1) |-> !irq);
endmodule

// File: tb/sdhost_ctrl_regs_test.sv
module sdhost_ctrl_regs_test;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ready;
  logic ev_xfer_done = 0, ev_prog_done = 0, ev_cmd_done = 0, ev_rx_req = 0;
  logic ev_tx_req = 0, ev_sdio = 0, ev_rd_tmo = 0, ev_resp_tmo = 0;
  logic card_clk, op_start, irq;
  logic [3:0] aux_strobe;
  logic [11:0] cmd_cfg;
  logic [15:0] resp_limit;
  logic [31:0] read_limit;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sdhost_ctrl_regs uut (.*);

  typedef struct packed {
    logic        we;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b0, 5'h04, 32'h0, 32'h0000_0000, 4'd1},
    '{1'b0, 5'h08, 32'h0, 32'h0000_0000, 4'd1},
    '{1'b0, 5'h0C, 32'h0, 32'h0000_0000, 4'd1},
    '{1'b0, 5'h10, 32'h0, 32'h0000_FFFF, 4'd1},
    '{1'b0, 5'h14, 32'h0, 32'hFFFF_FFFF, 4'd1},
    '{1'b0, 5'h18, 32'h0, 32'h0000_03FF, 4'd1},
    '{1'b0, 5'h1C, 32'h0, 32'h0000_0000, 4'd1},
    '{1'b1, 5'h08, 32'hFFFF_FFFA, 32'h0, 4'd3},
    '{1'b0, 5'h08, 32'h0, 32'h0000_0002, 4'd3},
    '{1'b1, 5'h0C, 32'hFFFF_F5A3, 32'h0, 4'd10},
    '{1'b0, 5'h0C, 32'h0, 32'h0000_05A3, 4'd10},
    '{1'b1, 5'h10, 32'hABCD_1234, 32'h0, 4'd10},
    '{1'b0, 5'h10, 32'h0, 32'h0000_1234, 4'd10},
    '{1'b1, 5'h14, 32'hDEAD_BEEF, 32'h0, 4'd10},
    '{1'b0, 5'h14, 32'h0, 32'hDEAD_BEEF, 4'd10},
    '{1'b0, 5'h00, 32'h0, 32'h0000_0000, 4'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic rdy);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata; rdy = bus_ready;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic run_len(output int len);
    logic v;
    int guard;
    guard = 0;
    v = card_clk;
    while (card_clk == v && guard < 400) begin @(negedge clk); guard++; end
    v = card_clk; len = 0;
    while (card_clk == v && len < 400) begin @(negedge clk); len++; end
  endtask

  task automatic pulse_ev(input logic [9:0] e);
    {ev_resp_tmo, ev_rd_tmo, ev_sdio, ev_tx_req, ev_rx_req} = e[9:5];
    {ev_cmd_done, ev_prog_done, ev_xfer_done} = e[2:0];
    @(negedge clk);
    {ev_resp_tmo, ev_rd_tmo, ev_sdio, ev_tx_req, ev_rx_req, ev_cmd_done, ev_prog_done, ev_xfer_done} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic rdy;
    int len, busy_n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 card_clk", {31'd0, card_clk}, 0);
    chk("R1 op_start", {31'd0, op_start}, 0);

    foreach (VECS[i]) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, d, rdy);
        chk($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
      end
    end
    chk("R10 cmd_cfg port", {20'd0, cmd_cfg}, 32'h5A3);
    chk("R10 resp_limit port", {16'd0, resp_limit}, 32'h1234);
    chk("R10 read_limit port", read_limit, 32'hDEADBEEF);

    // R11 ready follows request
    rd(5'h04, d, rdy);
    chk("R11 ready on access", {31'd0, rdy}, 1);
    chk("R11 ready idle", {31'd0, bus_ready}, 0);

    // R2 / R3 clock start and divider
    wr(5'h08, 32'h2);
    wr(5'h00, 32'h2);
    rd(5'h04, d, rdy);
    chk("R2 clock enabled bit8", d, 32'h100);
    run_len(len); chk("R3 phase rate2", len, 4);
    run_len(len); chk("R3 phase rate2 next", len, 4);
    wr(5'h08, 32'h0);
    run_len(len); run_len(len); chk("R3 phase rate0", len, 1);
    wr(5'h08, 32'h5);
    run_len(len); run_len(len); chk("R3 phase rate5", len, 32);
    wr(5'h00, 32'h1);
    rd(5'h04, d, rdy);
    chk("R2 stopped bit8", d, 32'h0);
    repeat (3) begin
      @(negedge clk);
      chk("R2 card_clk low after stop", {31'd0, card_clk}, 0);
    end
    wr(5'h00, 32'h3);
    rd(5'h04, d, rdy);
    chk("R2 stop wins over start", d, 32'h0);

    // R4 strobes
    wr(5'h00, 32'h4);
    chk("R4 op_start pulse", {31'd0, op_start}, 1);
    @(negedge clk);
    chk("R4 op_start one cycle", {31'd0, op_start}, 0);
    wr(5'h00, 32'hF0);
    chk("R4 aux strobes", {28'd0, aux_strobe}, 32'hF);
    @(negedge clk);
    chk("R4 aux strobes one cycle", {28'd0, aux_strobe}, 0);

    // R6 / R9 interrupt path
    wr(5'h18, 32'h3FF);
    @(negedge clk);
    pulse_ev(10'h004);
    rd(5'h1C, d, rdy);
    chk("R6 cmd done sets bit2", d, 32'h004);
    chk("R9 masked source quiet", {31'd0, irq}, 0);
    wr(5'h18, 32'h3FB);
    chk("R9 irq one cycle later", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R9 irq raised", {31'd0, irq}, 1);
    wr(5'h1C, 32'h004);
    @(negedge clk);
    chk("R7 irq drops after clear", {31'd0, irq}, 0);
    rd(5'h1C, d, rdy);
    chk("R7 status cleared", d, 32'h0);
    pulse_ev(10'h3E7);
    rd(5'h1C, d, rdy);
    chk("R6 all sources, bits 3 and 4 zero", d, 32'h3E7);

    // R8 event versus clear in one cycle
    ev_sdio = 1; bus_en = 1; bus_we = 1; bus_addr = 5'h1C; bus_wdata = 32'h3E7;
    @(negedge clk);
    ev_sdio = 0; bus_en = 0; bus_we = 0;
    rd(5'h1C, d, rdy);
    chk("R8 event wins over clear", d, 32'h080);
    wr(5'h1C, 32'h0);
    rd(5'h1C, d, rdy);
    chk("R7 write zero keeps bit", d, 32'h080);

    // R5 reset countdown
    wr(5'h00, 32'h2);
    wr(5'h0C, 32'h777);
    wr(5'h00, 32'h8);
    busy_n = 0;
    while (uut.bus_rdata[15] === 1'b1 || busy_n == 0) begin
      bus_addr = 5'h04;
      #1 if (bus_rdata[15] !== 1'b1) break;
      busy_n++;
      @(negedge clk);
      if (busy_n > 50) break;
    end
    chk("R5 busy cycles", busy_n, 8);
    rd(5'h0C, d, rdy); chk("R5 cmd default", d, 0);
    rd(5'h18, d, rdy); chk("R5 mask default", d, 32'h3FF);
    rd(5'h1C, d, rdy); chk("R5 status default", d, 0);
    rd(5'h10, d, rdy); chk("R5 resp timeout ones", d, 32'hFFFF);
    rd(5'h04, d, rdy); chk("R5 clock off", d, 0);

    wr(5'h00, 32'h8);
    bus_en = 1; bus_we = 1; bus_addr = 5'h00; bus_wdata = 32'h4;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    chk("R5 start ignored while busy", {31'd0, op_start}, 0);
    repeat (10) @(negedge clk);
    rd(5'h04, d, rdy);
    chk("R5 busy released", d, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule